// File: doc/BRIEF.md
# Flash Programming Command Sequencer

This block drives the flash programming service of a small microcontroller through its two-wire debug port. It does not generate bit timing. It sits above a frame engine that performs four primitive operations: write the address register, read the address register, write the data register and read the data register. The block turns a host command into the ordered list of those operations that the target expects.

The block handles five commands: arm programming, disarm, whole-device erase, block read and block write. After every operation that the target must digest, the block polls the target's address register, either for the input-busy flag or for the output-ready flag. After each command or header phase it reads a status byte and stops at the first fault.

Payload bytes leave the block on a valid/ready stream for reads and enter it on a second stream for writes. Each command ends with a one-cycle `done` pulse. An error flag and a count of the bytes actually moved are valid alongside it.

Top module: `flash_seq`

## Requirements
- R1: After reset, `busy`, `done`, `f_req`, `rd_valid` and `wr_ready` are 0, `xfer_count` is 0, and programming is not armed.
- R2: Command code 0 (arm) does the following: it writes address 0x02, then writes data 0x02, then writes data 0x01, then waits SETTLE_CYCLES clock cycles, and then pulses `done`. Only after this completes without error is programming armed. A new arm command first clears the armed state.
- R3: Codes 2 (erase), 3 (read) and 4 (write) are refused while programming is not armed. Code 1 (disarm) clears the armed state, and any code from 5 to 7 is illegal. In each of these cases `done` rises in the cycle after the start edge, no frame operation is issued, and `error` is 1 (disarm: 0).
- R4: A status byte read from the data register must equal 0x0D. Any other value ends the command at once with `error` = 1.
- R5: The input-busy poll reads the address register until bit 1 is 0. After IB_TRIES reads that all show the bit set, the command ends with an error.
- R6: The output-ready poll reads the address register until bit 0 is 1. After OR_TRIES reads that all show the bit clear, the command ends with an error.
- R7: Erase runs in this order:
  - select address 0xB4 and write data 0x03;
  - input-busy poll, output-ready poll, status check;
  - write 0xDE, 0xAD and 0xA5, each followed by an input-busy poll;
  - a final output-ready poll.
- R8: Read writes 0x06, then runs the input-busy poll, the output-ready poll and a status check. It then writes the offset high byte, the offset low byte and the length, each followed by an input-busy poll. It then runs an output-ready poll and a status check. After that, each byte is one output-ready poll followed by a data read, and the byte is delivered on the read stream.
- R9: Write follows the same header as read but with code 0x07. Each payload byte is taken from the write stream, written to the data register and followed by an input-busy poll. The command ends with one output-ready poll.
- R10: The transfer length is the minimum of MAX_LEN (128), the requested count, and FLASH_BYTES (15360) minus the offset. `xfer_count` reports the bytes moved.
- R11: A read at or past the end of flash, or a read with a count of 0, finishes with no frame operation, no error and zero bytes. A write at or past the end of flash finishes with an error and no frame operation.
- R12: A frame timeout reported with `f_ack` ends the command: `done` and `error` are 1 in the next cycle, and no further frame operation is issued.
- R13: `f_req` is held with stable `f_op` and `f_wdata` until `f_ack`. `rd_valid` is held with stable `rd_data` until `rd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a command; accepted only when not busy |
| cmd | input | 3 | 0 arm, 1 disarm, 2 erase, 3 read, 4 write |
| offset | input | 16 | Flash byte offset |
| count | input | 16 | Requested byte count |
| busy | output | 1 | A command is running |
| done | output | 1 | One-cycle end-of-command pulse |
| error | output | 1 | Result of the last command, valid with done |
| xfer_count | output | 8 | Bytes moved by the last command |
| f_req | output | 1 | Frame operation request |
| f_op | output | 2 | 0 address write, 1 address read, 2 data write, 3 data read |
| f_wdata | output | 8 | Byte for address or data write |
| f_ack | input | 1 | Frame operation complete |
| f_tmo | input | 1 | Frame operation timed out (with f_ack) |
| f_rdata | input | 8 | Byte returned by a read operation |
| rd_valid | output | 1 | Read stream byte valid |
| rd_ready | input | 1 | Read stream consumer ready |
| rd_data | output | 8 | Read stream byte |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Block accepts a write stream byte |
| wr_data | input | 8 | Write stream byte |

## Verification
A refused, illegal or out-of-range command raises `done` in the cycle after the start edge, so the bench samples it at the very next falling edge. Every other result is due one cycle after the acknowledge of the last frame operation, or, for arm, one cycle after the settle count expires. The bench therefore waits for `done` at falling edges and then compares the logged frame operations, the stream bytes, `error` and `xfer_count`. For a timeout, it checks after a few further cycles that the operation count has not grown past the operation that timed out.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int SETTLE_CYCLES = 3125000,
  parameter int IB_TRIES      = 20,
  parameter int OR_TRIES      = 10000,
  parameter int MAX_LEN       = 128,
  parameter int FLASH_BYTES   = 15360
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  cmd,
  input  logic [15:0] offset,
  input  logic [15:0] count,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic [7:0]  xfer_count,
  output logic        f_req,
  output logic [1:0]  f_op,
  output logic [7:0]  f_wdata,
  input  logic        f_ack,
  input  logic        f_tmo,
  input  logic [7:0]  f_rdata,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [7:0]  rd_data,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [7:0]  wr_data
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam int TW = $clog2((IB_TRIES > OR_TRIES ? IB_TRIES : OR_TRIES) + 1);
  localparam logic [1:0] OP_AW = 2'd0, OP_AR = 2'd1, OP_DW = 2'd2, OP_DR = 2'd3;
  localparam logic [2:0] C_ARM = 3'd0, C_DISARM = 3'd1, C_ERASE = 3'd2,
                         C_READ = 3'd3, C_WRITE = 3'd4;
  localparam logic [7:0] STAT_OK = 8'h0D;

  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_KEY1, S_KEY2, S_SETTLE, S_CMD, S_IB, S_OR,
    S_STAT, S_HDR, S_PULL, S_WDAT, S_RDAT, S_PUSH, S_FIN
  } st_t;

  st_t         state;
  logic [1:0]  stage, idx;
  logic [TW-1:0] tries;
  logic [SW-1:0] settle;
  logic [7:0]  cnt, len, byte_r;
  logic [2:0]  op_cmd;
  logic [15:0] off_r;
  logic        armed, err_r;

  logic [16:0] remain;
  logic [16:0] len_a;
  logic [7:0]  len_calc;
  logic        past_end, is_flash_cmd;

  assign past_end     = {1'b0, offset} >= 17'(FLASH_BYTES);
  assign remain       = 17'(FLASH_BYTES) - {1'b0, offset};
  assign len_a        = ({1'b0, count} < 17'(MAX_LEN)) ? {1'b0, count} : 17'(MAX_LEN);
  assign len_calc     = (remain < len_a) ? remain[7:0] : len_a[7:0];
  assign is_flash_cmd = (cmd == C_ERASE) || (cmd == C_READ) || (cmd == C_WRITE);

  assign busy       = state != S_IDLE;
  assign done       = state == S_FIN;
  assign error      = err_r;
  assign xfer_count = cnt;
  assign rd_valid   = state == S_PUSH;
  assign rd_data    = byte_r;
  assign wr_ready   = state == S_PULL;

  assign f_req = (state == S_SEL) || (state == S_KEY1) || (state == S_KEY2) ||
                 (state == S_CMD) || (state == S_IB) || (state == S_OR) ||
                 (state == S_STAT) || (state == S_HDR) || (state == S_WDAT) ||
                 (state == S_RDAT);

  logic [7:0] hdr_byte, cmd_code;

  always_comb begin
    case (op_cmd)
      C_ERASE: cmd_code = 8'h03;
      C_READ:  cmd_code = 8'h06;
      default: cmd_code = 8'h07;
    endcase
    if (op_cmd == C_ERASE)
      hdr_byte = (idx == 2'd0) ? 8'hDE : (idx == 2'd1) ? 8'hAD : 8'hA5;
    else
      hdr_byte = (idx == 2'd0) ? off_r[15:8] : (idx == 2'd1) ? off_r[7:0] : len;
  end

  always_comb begin
    f_op    = OP_DW;
    f_wdata = 8'h00;
    case (state)
      S_SEL:  begin f_op = OP_AW; f_wdata = (op_cmd == C_ARM) ? 8'h02 : 8'hB4; end
      S_KEY1: f_wdata = 8'h02;
      S_KEY2: f_wdata = 8'h01;
      S_CMD:  f_wdata = cmd_code;
      S_HDR:  f_wdata = hdr_byte;
      S_WDAT: f_wdata = byte_r;
      S_IB, S_OR:     f_op = OP_AR;
      S_STAT, S_RDAT: f_op = OP_DR;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      stage  <= 2'd0;
      idx    <= 2'd0;
      tries  <= '0;
      settle <= '0;
      cnt    <= 8'd0;
      len    <= 8'd0;
      byte_r <= 8'd0;
      op_cmd <= C_ARM;
      off_r  <= 16'd0;
      armed  <= 1'b0;
      err_r  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          err_r  <= 1'b0;
          cnt    <= 8'd0;
          stage  <= 2'd0;
          idx    <= 2'd0;
          tries  <= '0;
          settle <= '0;
          op_cmd <= cmd;
          off_r  <= offset;
          len    <= len_calc;
          state  <= S_FIN;
          if (cmd == C_ARM) begin
            armed <= 1'b0;
            state <= S_SEL;
          end else if (cmd == C_DISARM) begin
            armed <= 1'b0;
          end else if (!is_flash_cmd || !armed) begin
            err_r <= 1'b1;
          end else if (cmd == C_READ) begin
            if (!past_end && count != 16'd0) state <= S_SEL;
          end else if (cmd == C_WRITE && past_end) begin
            err_r <= 1'b1;
          end else begin
            state <= S_SEL;
          end
        end
        S_SETTLE: begin
          if (settle == SW'(SETTLE_CYCLES - 1)) begin
            armed <= 1'b1;
            state <= S_FIN;
          end else begin
            settle <= settle + 1'b1;
          end
        end
        S_PUSH: if (rd_ready) begin
          cnt   <= cnt + 1'b1;
          state <= (cnt + 8'd1 == len) ? S_FIN : S_OR;
        end
        S_PULL: if (wr_valid) begin
          byte_r <= wr_data;
          state  <= S_WDAT;
        end
        S_FIN: state <= S_IDLE;
        default: if (f_req && f_ack) begin
          tries <= '0;
          if (f_tmo) begin
            err_r <= 1'b1;
            state <= S_FIN;
          end else begin
            case (state)
              S_SEL:  state <= (op_cmd == C_ARM) ? S_KEY1 : S_CMD;
              S_KEY1: state <= S_KEY2;
              S_KEY2: state <= S_SETTLE;
              S_CMD, S_HDR: state <= S_IB;
              S_WDAT: begin
                cnt   <= cnt + 1'b1;
                state <= S_IB;
              end
              S_RDAT: begin
                byte_r <= f_rdata;
                state  <= S_PUSH;
              end
              S_IB: begin
                if (f_rdata[1]) begin
                  if (tries == TW'(IB_TRIES - 1)) begin
                    err_r <= 1'b1;
                    state <= S_FIN;
                  end else begin
                    tries <= tries + 1'b1;
                  end
                end else if (stage == 2'd0) begin
                  state <= S_OR;
                end else if (stage == 2'd1) begin
                  if (idx == 2'd2) state <= S_OR;
                  else begin
                    idx   <= idx + 1'b1;
                    state <= S_HDR;
                  end
                end else begin
                  state <= (cnt == len) ? S_OR : S_PULL;
                end
              end
              S_OR: begin
                if (!f_rdata[0]) begin
                  if (tries == TW'(OR_TRIES - 1)) begin
                    err_r <= 1'b1;
                    state <= S_FIN;
                  end else begin
                    tries <= tries + 1'b1;
                  end
                end else if (stage == 2'd0) begin
                  state <= S_STAT;
                end else if (stage == 2'd1) begin
                  state <= (op_cmd == C_ERASE) ? S_FIN : S_STAT;
                end else begin
                  state <= (op_cmd == C_WRITE) ? S_FIN : S_RDAT;
                end
              end
              S_STAT: begin
                if (f_rdata != STAT_OK) begin
                  err_r <= 1'b1;
                  state <= S_FIN;
                end else if (stage == 2'd0) begin
                  stage <= 2'd1;
                  idx   <= 2'd0;
                  state <= S_HDR;
                end else begin
                  stage <= 2'd2;
                  if (op_cmd == C_WRITE) state <= (len == 8'd0) ? S_OR : S_PULL;
                  else state <= S_OR;
                end
              end
              default: state <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [2:0] cmd,
  input logic       busy,
  input logic       done,
  input logic       error,
  input logic [7:0] xfer_count,
  input logic       f_req,
  input logic [1:0] f_op,
  input logic [7:0] f_wdata,
  input logic       f_ack,
  input logic       f_tmo,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       armed
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    f_req && !f_ack |=> f_req && $stable(f_op) && $stable(f_wdata)); // R13
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R13
  AST_LOCKED_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !armed && (cmd == 3'd2 || cmd == 3'd3 || cmd == 3'd4)
      |=> done && error && !f_req); // R3
  AST_TMO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    f_req && f_ack && f_tmo |=> done && error && !f_req); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R1
  AST_XFER_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_count <= 8'd128); // R10
endmodule

bind flash_seq flash_seq_checker u_flash_seq_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .busy(busy),
  .done(done), .error(error), .xfer_count(xfer_count), .f_req(f_req),
  .f_op(f_op), .f_wdata(f_wdata), .f_ack(f_ack), .f_tmo(f_tmo),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .armed(armed)
);

// File: tb/flash_seq_bench.sv
module flash_seq_bench;
  localparam int SETTLE = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [15:0] offset = 16'd0, count = 16'd0;
  logic busy, done, error;
  logic [7:0] xfer_count;
  logic f_req;
  logic [1:0] f_op;
  logic [7:0] f_wdata;
  logic f_ack = 1'b0, f_tmo = 1'b0;
  logic [7:0] f_rdata = 8'd0;
  logic rd_valid, wr_ready;
  logic rd_ready = 1'b1;
  logic [7:0] rd_data;
  logic wr_valid = 1'b1;
  logic [7:0] wr_data = 8'd0;

  always #4 clk = ~clk;

  flash_seq #(.SETTLE_CYCLES(SETTLE)) u_flash_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .offset(offset),
    .count(count), .busy(busy), .done(done), .error(error),
    .xfer_count(xfer_count), .f_req(f_req), .f_op(f_op), .f_wdata(f_wdata),
    .f_ack(f_ack), .f_tmo(f_tmo), .f_rdata(f_rdata), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data)
  );

  int n_chk = 0, n_bad = 0;
  int ops = 0, ar_n = 0, aw_n = 0, dw_n = 0, rd_n = 0, wi = 0, dr_i = 0;
  int tmo_at = -1, cycles = 0;
  logic [7:0] ar_val = 8'h01;
  logic [7:0] aw_last = 8'h00;
  logic [7:0] dw_log [0:255];
  logic [7:0] rd_got [0:255];
  logic [7:0] dr_q [0:255];
  logic [7:0] wq [0:255];
  logic toggle_rdy = 1'b0;

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // target model for the frame layer
  initial forever begin
    @(negedge clk);
    if (f_req) begin
      ops++;
      case (f_op)
        2'd0: begin aw_n++; aw_last = f_wdata; end
        2'd1: ar_n++;
        2'd2: begin dw_log[dw_n] = f_wdata; dw_n++; end
        default: ;
      endcase
      @(negedge clk);
      f_ack = 1'b1;
      f_tmo = (ops == tmo_at);
      if (f_op == 2'd1) f_rdata = ar_val;
      else if (f_op == 2'd3) begin f_rdata = dr_q[dr_i]; dr_i++; end
      @(negedge clk);
      f_ack = 1'b0;
      f_tmo = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (toggle_rdy) rd_ready = ~rd_ready; else rd_ready = 1'b1;
    #1;
    if (rd_valid && rd_ready) begin rd_got[rd_n] = rd_data; rd_n++; end
  end

  initial forever begin
    @(negedge clk);
    #1;
    if (wr_valid && wr_ready) begin
      @(posedge clk);
      #1;
      wi++;
      wr_data = wq[wi];
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic clear_log();
    ops = 0; ar_n = 0; aw_n = 0; dw_n = 0; rd_n = 0; dr_i = 0;
    tmo_at = -1; ar_val = 8'h01; toggle_rdy = 1'b0;
    wi = 0; wr_data = wq[0];
    for (int i = 0; i < 256; i++) dr_q[i] = 8'h0D;
  endtask

  task automatic run(input logic [2:0] c, input int off, input int n);
    @(negedge clk);
    cmd = c; offset = 16'(off); count = 16'(n); start = 1'b1;
    cycles = 0;
    @(negedge clk);
    start = 1'b0;
    while (!done) begin @(negedge clk); cycles++; end
  endtask

  task automatic t_reset();
    chk("R1 busy", busy == 1'b0, busy, 0);
    chk("R1 done", done == 1'b0, done, 0);
    chk("R1 f_req", f_req == 1'b0, f_req, 0);
    chk("R1 streams", rd_valid == 1'b0 && wr_ready == 1'b0, rd_valid, 0);
    chk("R1 xfer", xfer_count == 8'd0, xfer_count, 0);
  endtask

  task automatic t_refused(input logic [2:0] c, input logic exp_err);
    clear_log();
    @(negedge clk);
    cmd = c; offset = 0; count = 4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 done next cycle", done == 1'b1, done, 1);
    chk("R3 error", error == exp_err, error, exp_err);
    chk("R3 no frame ops", ops == 0, ops, 0);
  endtask

  task automatic t_arm();
    clear_log();
    run(3'd0, 0, 0);
    chk("R2 error", error == 1'b0, error, 0);
    chk("R2 select addr", aw_last == 8'h02 && aw_n == 1, aw_last, 2);
    chk("R2 key count", dw_n == 2, dw_n, 2);
    chk("R2 key1", dw_log[0] == 8'h02, dw_log[0], 2);
    chk("R2 key2", dw_log[1] == 8'h01, dw_log[1], 1);
    chk("R2 settle wait", cycles > SETTLE, cycles, SETTLE + 1);
  endtask

  task automatic t_erase();
    clear_log();
    run(3'd2, 0, 0);
    chk("R7 error", error == 1'b0, error, 0);
    chk("R7 addr", aw_last == 8'hB4, aw_last, 8'hB4);
    chk("R7 dw count", dw_n == 4, dw_n, 4);
    chk("R7 code", dw_log[0] == 8'h03, dw_log[0], 3);
    chk("R7 arm1", dw_log[1] == 8'hDE, dw_log[1], 8'hDE);
    chk("R7 arm2", dw_log[2] == 8'hAD, dw_log[2], 8'hAD);
    chk("R7 arm3", dw_log[3] == 8'hA5, dw_log[3], 8'hA5);
    chk("R7 polls", ar_n == 6, ar_n, 6);
  endtask

  task automatic t_read(input int off, input int n, input int exp_len, input logic tog);
    clear_log();
    toggle_rdy = tog;
    for (int i = 0; i < exp_len; i++) dr_q[i + 2] = 8'(i * 37 + 5);
    run(3'd3, off, n);
    chk("R8 error", error == 1'b0, error, 0);
    chk("R8 code", dw_log[0] == 8'h06, dw_log[0], 6);
    chk("R8 off hi", dw_log[1] == 8'(off >> 8), dw_log[1], (off >> 8) & 255);
    chk("R8 off lo", dw_log[2] == 8'(off), dw_log[2], off & 255);
    chk("R10 len byte", dw_log[3] == 8'(exp_len), dw_log[3], exp_len);
    chk("R10 xfer", xfer_count == 8'(exp_len), xfer_count, exp_len);
    chk("R8 stream count", rd_n == exp_len, rd_n, exp_len);
    for (int i = 0; i < exp_len; i++)
      if (rd_got[i] != 8'(i * 37 + 5))
        chk("R8 stream byte", 1'b0, rd_got[i], (i * 37 + 5) & 255);
  endtask

  task automatic t_write();
    clear_log();
    wq[0] = 8'hA1; wq[1] = 8'hB2; wq[2] = 8'hC3; wq[3] = 8'hFF;
    wi = 0; wr_data = wq[0];
    run(3'd4, 16'h0100, 3);
    chk("R9 error", error == 1'b0, error, 0);
    chk("R9 dw count", dw_n == 7, dw_n, 7);
    chk("R9 code", dw_log[0] == 8'h07, dw_log[0], 7);
    chk("R9 hdr", dw_log[1] == 8'h01 && dw_log[2] == 8'h00 && dw_log[3] == 8'h03, dw_log[3], 3);
    chk("R9 data", dw_log[4] == 8'hA1 && dw_log[5] == 8'hB2 && dw_log[6] == 8'hC3, dw_log[6], 8'hC3);
    chk("R9 xfer", xfer_count == 8'd3, xfer_count, 3);
    chk("R9 polls", ar_n == 10, ar_n, 10);
  endtask

  task automatic t_bounds();
    clear_log();
    run(3'd3, 15360, 4);
    chk("R11 read past end err", error == 1'b0, error, 0);
    chk("R11 read past end ops", ops == 0 && xfer_count == 0, ops, 0);
    clear_log();
    run(3'd3, 0, 0);
    chk("R11 read zero count", ops == 0 && error == 1'b0, ops, 0);
    clear_log();
    run(3'd4, 15400, 2);
    chk("R11 write past end err", error == 1'b1, error, 1);
    chk("R11 write past end ops", ops == 0, ops, 0);
  endtask

  task automatic t_bad_status();
    clear_log();
    dr_q[0] = 8'h02;
    run(3'd2, 0, 0);
    chk("R4 error", error == 1'b1, error, 1);
    chk("R4 stops", ops == 5 && dw_n == 1, ops, 5);
  endtask

  task automatic t_ib_limit();
    clear_log();
    ar_val = 8'h03;
    run(3'd2, 0, 0);
    chk("R5 error", error == 1'b1, error, 1);
    chk("R5 tries", ar_n == 20, ar_n, 20);
  endtask

  task automatic t_or_limit();
    clear_log();
    ar_val = 8'h00;
    run(3'd2, 0, 0);
    chk("R6 error", error == 1'b1, error, 1);
    chk("R6 tries", ar_n == 10001, ar_n, 10001);
  endtask

  task automatic t_timeout();
    clear_log();
    tmo_at = 3;
    run(3'd2, 0, 0);
    chk("R12 error", error == 1'b1, error, 1);
    repeat (6) @(negedge clk);
    chk("R12 no further ops", ops == 3, ops, 3);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) wq[i] = 8'h00;
    clear_log();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_refused(3'd2, 1'b1);
    t_refused(3'd3, 1'b1);
    t_refused(3'd7, 1'b1);
    t_arm();
    t_erase();
    t_read(16'h1234, 4, 4, 1'b1);
    t_read(15358, 10, 2, 1'b0);
    t_read(0, 300, 128, 1'b0);
    t_write();
    t_bounds();
    t_bad_status();
    t_ib_limit();
    t_or_limit();
    t_timeout();
    t_refused(3'd1, 1'b0);
    t_refused(3'd4, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule